// File: doc/BRIEF.md
# Address-Striping Port Selector

This block picks one of four outgoing ports, numbered 2 to 5, for every memory request address. Each incoming port has its own two-bit mode setting. Most of the address space is interleaved in 4 KB blocks. The interleave runs either over all four outgoing ports or over one pair of them, ports 2/3 or ports 4/5.

One address window, from 2 TB up to 4 TB, is never interleaved. Each half of that window maps to one fixed port, and which port depends on the mode. The choice is registered together with the request in a single output stage. That stage holds the request while the downstream side stalls and accepts a new request every cycle when there is no stall.

Top module: `stripe_port_sel`

## Requirements
- R1: After reset, out_valid is 0, req_ready is 1, and every incoming port is in 4-way mode.
- R2: In 4-way mode (mode code 00), an address outside the 2–4 TB window goes to port 2 + addr[13:12].
- R3: In mode code 01 (pair 2/3), an address outside the window goes to port 2 when addr[12] is 0 and to port 3 when it is 1.
- R4: In mode code 10 (pair 4/5), an address outside the window goes to port 4 when addr[12] is 0 and to port 5 when it is 1.
- R5: Mode code 11 routes exactly like 4-way mode.
- R6: An address from 0x200_0000_0000 to 0x2FF_FFFF_FFFF goes to port 4 in mode 10 and to port 2 in every other mode, whatever its stripe bits are.
- R7: An address from 0x300_0000_0000 to 0x3FF_FFFF_FFFF goes to port 5 in mode 10 and to port 3 in every other mode.
- R8: Addresses at or above 4 TB are interleaved by the normal stripe rule (R2–R5) and do not fall into the fixed-port window.
- R9: Each incoming port (req_src) uses its own mode. A write through cfg_we/cfg_idx/cfg_mode changes only the port selected by cfg_idx, and the new mode applies from the next request.
- R10: While out_valid is 1 and out_ready is 0, out_addr, out_src and out_port stay stable, and req_ready is 0.
- R11: A request accepted at a clock edge appears on the outputs after that edge. While out_ready stays 1, a new request is accepted on every cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode write strobe |
| cfg_idx | input | SRC_W | Incoming port whose mode is written |
| cfg_mode | input | 2 | New mode: 00 4-way, 01 pair 2/3, 10 pair 4/5, 11 4-way |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Request address |
| req_src | input | SRC_W | Incoming port issuing the request |
| out_valid | output | 1 | Forwarded request present |
| out_ready | input | 1 | Downstream takes the forwarded request |
| out_addr | output | ADDR_W | Forwarded address |
| out_src | output | SRC_W | Forwarded incoming port index |
| out_port | output | 3 | Chosen outgoing port, 2 to 5 |

## Verification
The hardest case to reach is a stall during which a second request is already waiting. The bench holds out_ready low with a routed request in the output stage, then presents a different request and checks that nothing moves for several cycles. When it releases out_ready, the second request must take over in the very next cycle.

The other hard case is a pair of incoming ports with different modes, which share only the mode write path. The bench sends the same address from each of them and expects different ports.

// File: rtl/stripe_port_sel.sv
module stripe_port_sel #(
  parameter int ADDR_W     = 44,
  parameter int NUM_IN     = 4,
  parameter int STRIPE_LSB = 12,
  parameter int WIN_LSB    = 41,
  localparam int SRC_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SRC_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_src,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SRC_W-1:0]  out_src,
  output logic [2:0]        out_port
);
  localparam logic [1:0] MODE_PAIR_LO = 2'b01;
  localparam logic [1:0] MODE_PAIR_HI = 2'b10;

  logic [1:0] mode_q [NUM_IN];
  logic [1:0] cur_mode;
  logic       in_win;
  logic       win_top;
  logic [2:0] sel;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_IN; i++) begin
      if (!rst_n)
        mode_q[i] <= 2'b00;
      else if (cfg_we && cfg_idx == SRC_W'(i))
        mode_q[i] <= cfg_mode;
    end
  end

  always_comb begin
    cur_mode = 2'b00;
    for (int i = 0; i < NUM_IN; i++)
      if (req_src == SRC_W'(i)) cur_mode = mode_q[i];
  end

  assign in_win  = (req_addr[ADDR_W-1:WIN_LSB+1] == '0) && req_addr[WIN_LSB];
  assign win_top = req_addr[WIN_LSB-1];

  always_comb begin
    if (in_win)
      sel = (cur_mode == MODE_PAIR_HI) ? {2'b10, win_top} : {2'b01, win_top};
    else begin
      case (cur_mode)
        MODE_PAIR_LO: sel = {2'b01, req_addr[STRIPE_LSB]};
        MODE_PAIR_HI: sel = {2'b10, req_addr[STRIPE_LSB]};
        default:      sel = 3'd2 + {1'b0, req_addr[STRIPE_LSB+1:STRIPE_LSB]};
      endcase
    end
  end

  assign req_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_src   <= '0;
      out_port  <= 3'd2;
    end else if (req_ready) begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= req_addr;
        out_src  <= req_src;
        out_port <= sel;
      end
    end
  end
endmodule

// File: rtl/stripe_port_sel_chk.sv
module stripe_port_sel_chk #(
  parameter int ADDR_W  = 44,
  parameter int SRC_W   = 2,
  parameter int WIN_LSB = 41
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [SRC_W-1:0]  out_src,
  input logic [2:0]        out_port
);
  logic win_lo, win_hi;
  assign win_lo = (out_addr[ADDR_W-1:WIN_LSB+1] == '0) && out_addr[WIN_LSB] && !out_addr[WIN_LSB-1];
  assign win_hi = (out_addr[ADDR_W-1:WIN_LSB+1] == '0) && out_addr[WIN_LSB] &&  out_addr[WIN_LSB-1];

  // R11
  accept_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid && out_addr == $past(req_addr));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_port) && $stable(out_src));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready);

  // R6
  win_lo_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && win_lo |-> out_port == 3'd2 || out_port == 3'd4);

  // R7
  win_hi_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && win_hi |-> out_port == 3'd3 || out_port == 3'd5);

  // R2
  port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_port >= 3'd2 && out_port <= 3'd5);
endmodule

bind stripe_port_sel stripe_port_sel_chk #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .WIN_LSB(WIN_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_src(out_src), .out_port(out_port)
);

// File: tb/tb_stripe_port_sel.sv
module tb_stripe_port_sel;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_idx = 0;
  logic [1:0]  cfg_mode = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [43:0] req_addr = 0;
  logic [1:0]  req_src = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [43:0] out_addr;
  logic [1:0]  out_src;
  logic [2:0]  out_port;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0] shadow [4] = '{default: 2'b00};

  always #5 clk = ~clk;

  stripe_port_sel dut (.*);

  function automatic logic [2:0] expp(input logic [1:0] m, input logic [43:0] a);
    if (a[43:42] == 2'b00 && a[41])
      return (m == 2'b10) ? 3'd4 + {2'b0, a[40]} : 3'd2 + {2'b0, a[40]};
    case (m)
      2'b01:   return 3'd2 + {2'b0, a[12]};
      2'b10:   return 3'd4 + {2'b0, a[12]};
      default: return 3'd2 + {1'b0, a[13:12]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] idx, input logic [1:0] m);
    @(negedge clk); cfg_we = 1; cfg_idx = idx; cfg_mode = m;
    @(negedge clk); cfg_we = 0;
    shadow[idx] = m;
  endtask

  task automatic send(input string req, input logic [1:0] src, input logic [43:0] a);
    @(negedge clk); req_valid = 1; req_src = src; req_addr = a; out_ready = 1;
    @(negedge clk); req_valid = 0;
    chk(req, {63'b0, out_valid}, 64'd1);
    chk(req, 64'(out_addr), 64'(a));
    chk(req, 64'(out_src), 64'(src));
    chk(req, 64'(out_port), 64'(expp(shadow[src], a)));
  endtask

  task automatic t_reset;
    chk("R1 valid", {63'b0, out_valid}, 64'd0);
    chk("R1 ready", {63'b0, req_ready}, 64'd1);
    for (int s = 0; s < 4; s++)
      send("R1 default 4-way", 2'(s), 44'h000_0000_3000);
  endtask

  task automatic t_fourway;
    for (int b = 0; b < 8; b++)
      send("R2", 2'd0, 44'h012_3450_0000 + 44'(b) * 44'h1000 + 44'h7A4);
  endtask

  task automatic t_pairs;
    set_mode(2'd0, 2'b01);
    for (int b = 0; b < 4; b++) send("R3", 2'd0, 44'h0A0_0000_0000 + 44'(b) * 44'h1000);
    set_mode(2'd0, 2'b10);
    for (int b = 0; b < 4; b++) send("R4", 2'd0, 44'h1FF_FFFF_C000 + 44'(b) * 44'h1000);
    set_mode(2'd0, 2'b11);
    for (int b = 0; b < 4; b++) send("R5", 2'd0, 44'h000_8000_0000 + 44'(b) * 44'h1000);
  endtask

  task automatic t_window;
    for (int m = 0; m < 4; m++) begin
      set_mode(2'd1, 2'(m));
      send("R6 low edge",  2'd1, 44'h200_0000_0000);
      send("R6 stripe 3",  2'd1, 44'h2FF_FFFF_3000);
      send("R7 low edge",  2'd1, 44'h300_0000_1000);
      send("R7 top edge",  2'd1, 44'h3FF_FFFF_FFFF);
    end
  endtask

  task automatic t_above;
    set_mode(2'd2, 2'b10);
    send("R8 pair45", 2'd2, 44'h400_0000_1000);
    send("R8 pair45", 2'd2, 44'h412_0000_0000);
    set_mode(2'd2, 2'b00);
    send("R8 4way", 2'd2, 44'h400_0000_3000);
    send("R8 4way below", 2'd2, 44'h1FF_FFFF_2000);
  endtask

  task automatic t_independent;
    set_mode(2'd0, 2'b01);
    set_mode(2'd1, 2'b10);
    set_mode(2'd3, 2'b00);
    send("R9 src0", 2'd0, 44'h000_0000_3000);
    send("R9 src1", 2'd1, 44'h000_0000_3000);
    send("R9 src3", 2'd3, 44'h000_0000_3000);
    send("R9 src2", 2'd2, 44'h000_0000_2000);
  endtask

  task automatic t_stall;
    logic [43:0] a = 44'h000_0000_2000, b = 44'h000_0000_1000;
    @(negedge clk); req_valid = 1; req_src = 2'd3; req_addr = a; out_ready = 0;
    @(negedge clk); req_addr = b; req_src = 2'd0;
    for (int i = 0; i < 3; i++) begin
      chk("R10 addr held", 64'(out_addr), 64'(a));
      chk("R10 port held", 64'(out_port), 64'(expp(shadow[3], a)));
      chk("R10 ready low", {63'b0, req_ready}, 64'd0);
      @(negedge clk);
    end
    out_ready = 1;
    @(negedge clk); req_valid = 0;
    chk("R10 next addr", 64'(out_addr), 64'(b));
    chk("R10 next port", 64'(out_port), 64'(expp(shadow[0], b)));
    @(negedge clk);
    chk("R10 drained", {63'b0, out_valid}, 64'd0);
  endtask

  task automatic t_stream;
    logic [43:0] prev = '0;
    out_ready = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R11 stream valid", {63'b0, out_valid}, 64'd1);
        chk("R11 stream addr", 64'(out_addr), 64'(prev));
        chk("R11 stream port", 64'(out_port), 64'(expp(shadow[3], prev)));
        chk("R11 ready", {63'b0, req_ready}, 64'd1);
      end
      prev = 44'h000_0000_0000 + 44'(i) * 44'h1000;
      req_valid = 1; req_src = 2'd3; req_addr = prev;
    end
    @(negedge clk); req_valid = 0;
    chk("R11 last addr", 64'(out_addr), 64'(prev));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fourway();
    t_pairs();
    t_window();
    t_above();
    t_independent();
    t_stall();
    t_stream();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule